// File: doc/BRIEF.md
# Keypad Matrix Select Register

This block is the byte-wide keypad port seen by a processor. Eight active-low key inputs form two groups of four: a direction group (right, left, up, down) and a button group. The processor writes a byte whose bits 5:4 choose which group drives the four readable lines. A read returns bits 7:6 as ones, the stored select bits, and the four lines, where a held key reads as 0. With both groups selected the lines show a key as held if it is held in either group. With neither group selected the lines carry the inverted index of the active controller, so software can tell which of several pads is being scanned.

The lines are re-evaluated every clock, so a register write and any change of the key inputs both count. A one-cycle interrupt request pulses when any line falls from 1 to 0. When a remote controller is active (index not zero), the local keys are treated as released. An optional filter, enabled by a plain control pin, masks physically impossible direction pairs on the read path only. The interrupt still sees the raw lines.

The write port is a plain strobe with no back-pressure: every cycle with `wr_en` high is accepted. The read value is combinational from the stored select and the live inputs, so it needs no handshake either.

Top module: `keypad_matrix_reg`

## Requirements
- R1: After reset the select bits are 2'b11, `irq` is low, and with controller index 0 the read value is 0xFF.
- R2: A write stores `wr_data[5:4]` as the select, visible on `rd_data[5:4]` in the cycle after the write; other written bits have no effect, and `rd_data[7:6]` always reads 2'b11.
- R3: Select 2'b10 puts direction keys `key_n[7:4]` on `rd_data[3:0]` (bit 0 right, 1 left, 2 up, 3 down); a held key reads 0.
- R4: Select 2'b01 puts button keys `key_n[3:0]` on `rd_data[3:0]`.
- R5: Select 2'b00 shows line i low when `key_n[i]` or `key_n[i+4]` is low.
- R6: Select 2'b11 shows the bitwise inverse of the zero-extended controller index on `rd_data[3:0]`.
- R7: While the controller index is nonzero, all local keys read as released for selects 2'b00, 2'b01 and 2'b10.
- R8: `irq` is high for exactly the one cycle after an edge at which some line fell from 1 to 0 (through a key press or a select write); a rise of a line gives no pulse.
- R9: With `filter_en` high and select 2'b10, if right and left are both held, both read 1; the same holds for up and down; a pair with one key held is unchanged.
- R10: The filter has no effect for any other select or when `filter_en` is low, and never suppresses `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write byte; bits 5:4 are the group select |
| key_n | input | 8 | Active-low keys; 7:4 directions, 3:0 buttons |
| ctrl_idx | input | CTRL_W | Index of the active controller |
| filter_en | input | 1 | Enable the opposing-direction filter |
| rd_data | output | 8 | Read value of the register |
| irq | output | 1 | One-cycle keypad interrupt request |

## Verification
The bench builds the block with the default two-bit controller index, which reaches indices 0 to 3 and so covers both the zero index that lets local keys through and nonzero indices that mask them. That width also lets the neither-group read show every distinct upper-bit pattern a two-bit index can produce.

// File: rtl/jp_pkg.sv
package jp_pkg;
  localparam int GRP_W = 4;
  localparam int KEY_W = 2 * GRP_W;
  localparam int SEL_W = 2;
  localparam int SEL_LSB = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_BOTH = 2'b00,
    SEL_BTN  = 2'b01,
    SEL_DIR  = 2'b10,
    SEL_ID   = 2'b11
  } grp_sel_e;
endpackage

// File: rtl/jp_select_latch.sv
module jp_select_latch
  import jp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  output grp_sel_e         sel_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_o <= SEL_ID;
    else if (wr_en)
      sel_o <= grp_sel_e'(wr_sel);
  end

  // R1: select comes out of reset as neither group
  a_r1_reset_sel: assert property (@(posedge clk)
    $rose(rst_n) |-> (sel_o == SEL_ID || $past(wr_en)));
endmodule

// File: rtl/jp_line_mux.sv
module jp_line_mux
  import jp_pkg::*;
#(
  parameter int CTRL_W = 2
) (
  input  grp_sel_e          sel,
  input  logic [KEY_W-1:0]  key_n,
  input  logic [CTRL_W-1:0] ctrl_idx,
  output logic [GRP_W-1:0]  lines_o
);
  logic [KEY_W-1:0] held;
  logic [GRP_W-1:0] id_ext;
  logic [GRP_W-1:0] active;

  always_comb begin
    held   = (|ctrl_idx) ? '0 : ~key_n;
    id_ext = GRP_W'(ctrl_idx);
    unique case (sel)
      SEL_DIR:  active = held[KEY_W-1:GRP_W];
      SEL_BTN:  active = held[GRP_W-1:0];
      SEL_BOTH: active = held[KEY_W-1:GRP_W] | held[GRP_W-1:0];
      default:  active = id_ext;
    endcase
    lines_o = ~active;
  end
endmodule

// File: rtl/jp_fall_detect.sv
module jp_fall_detect
  import jp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] lines_i,
  output logic             irq_o
);
  logic [GRP_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '1;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= lines_i;
      irq_o  <= |(prev_q & ~lines_i);
    end
  end

  // R8: lines that were all high at the last edge cannot have fallen
  a_r8_quiet_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lines_i) == '1 && $past(rst_n)) |-> !irq_o);
endmodule

// File: rtl/jp_read_filter.sv
module jp_read_filter
  import jp_pkg::*;
(
  input  logic             filter_en,
  input  grp_sel_e         sel,
  input  logic [GRP_W-1:0] lines_i,
  output logic [7:0]       rd_o
);
  localparam int PAIRS = GRP_W / 2;
  logic [GRP_W-1:0] shown;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic both_held;
    assign both_held = (lines_i[2*p +: 2] == 2'b00) && filter_en && (sel == SEL_DIR);
    assign shown[2*p +: 2] = both_held ? 2'b11 : lines_i[2*p +: 2];
  end

  assign rd_o = {2'b11, sel, shown};
endmodule

// File: rtl/keypad_matrix_reg.sv
module keypad_matrix_reg
  import jp_pkg::*;
#(
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [KEY_W-1:0]  key_n,
  input  logic [CTRL_W-1:0] ctrl_idx,
  input  logic              filter_en,
  output logic [7:0]        rd_data,
  output logic              irq
);
  grp_sel_e         sel;
  logic [GRP_W-1:0] lines;

  jp_select_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_data[SEL_LSB +: SEL_W]),
    .sel_o  (sel)
  );

  jp_line_mux #(.CTRL_W(CTRL_W)) u_mux (
    .sel      (sel),
    .key_n    (key_n),
    .ctrl_idx (ctrl_idx),
    .lines_o  (lines)
  );

  jp_fall_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i (lines),
    .irq_o   (irq)
  );

  jp_read_filter u_filt (
    .filter_en (filter_en),
    .sel       (sel),
    .lines_i   (lines),
    .rd_o      (rd_data)
  );

  a_r2_sel_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[5:4] == $past(wr_data[5:4]));

  a_r2_top_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b11);

  a_r6_id_on_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:4] == 2'b11) |-> rd_data[3:0] == ~GRP_W'(ctrl_idx));

  a_r7_remote_masks_keys: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ctrl_idx) && rd_data[5:4] != 2'b11) |-> rd_data[3:0] == '1);

  a_r9_no_opposed_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_en && rd_data[5:4] == 2'b10) |-> (rd_data[1:0] != 2'b00 && rd_data[3:2] != 2'b00));
endmodule

// File: tb/keypad_matrix_reg_test.sv
module keypad_matrix_reg_test;
  localparam int CLK_NS = 10;
  localparam int NVEC = 12;
  // {select[1:0], key_n[7:0], ctrl[1:0], filter, expected[7:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {2'b10, 8'b1110_1111, 2'd0, 1'b0, 8'hEE},  // R3 right held
    {2'b01, 8'b1111_1010, 2'd0, 1'b0, 8'hDA},  // R4 buttons 0,2
    {2'b00, 8'b0111_1110, 2'd0, 1'b0, 8'hC6},  // R5 merge
    {2'b11, 8'b0000_0000, 2'd0, 1'b0, 8'hFF},  // R6 index 0
    {2'b11, 8'b1111_1111, 2'd2, 1'b0, 8'hFD},  // R6 index 2
    {2'b10, 8'b0000_0000, 2'd1, 1'b0, 8'hEF},  // R7 remote masks
    {2'b10, 8'b1100_1111, 2'd0, 1'b1, 8'hEF},  // R9 left+right
    {2'b10, 8'b0011_1111, 2'd0, 1'b1, 8'hEF},  // R9 up+down
    {2'b10, 8'b1100_1111, 2'd0, 1'b0, 8'hEC},  // R10 filter off
    {2'b01, 8'b1111_1100, 2'd0, 1'b1, 8'hDC},  // R10 not directions
    {2'b10, 8'b0100_1111, 2'd0, 1'b1, 8'hE7},  // R9 single pair masked
    {2'b00, 8'b1111_1111, 2'd3, 1'b0, 8'hCF}   // R7 merge, remote
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] key_n = 8'hFF;
  logic [1:0] ctrl_idx = 2'd0;
  logic       filter_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  keypad_matrix_reg #(.CTRL_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .key_n(key_n), .ctrl_idx(ctrl_idx), .filter_en(filter_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {2'b01, s, 4'b0110};
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset read", rd_data, 8'hFF);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      do_write(VEC[v][20:19]);
      key_n = VEC[v][18:11];
      ctrl_idx = VEC[v][10:9];
      filter_en = VEC[v][8];
      @(negedge clk);
      chk($sformatf("R2 R3-R10 vector %0d", v), rd_data, VEC[v][7:0]);
    end

    // R8: press gives one pulse, release gives none
    key_n = 8'hFF; ctrl_idx = 2'd0; filter_en = 1'b0;
    do_write(2'b01);
    idle(3);
    key_n[2] = 1'b0;
    @(negedge clk);
    chk("R8 pulse on press", {7'd0, irq}, 8'h01);
    @(negedge clk);
    chk("R8 pulse ends", {7'd0, irq}, 8'h00);
    key_n = 8'hFF;
    @(negedge clk);
    chk("R8 no pulse on release", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R8 still quiet", {7'd0, irq}, 8'h00);

    // R8: unselected key press does nothing; select write exposes it
    key_n[5] = 1'b0;
    idle(2);
    chk("R8 hidden group quiet", {7'd0, irq}, 8'h00);
    chk("R4 hidden group read", rd_data, 8'hDF);
    do_write(2'b10);
    chk("R8 write edge not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R8 pulse after select write", {7'd0, irq}, 8'h01);

    // R10: filtered pair still raises irq
    key_n = 8'hFF;
    filter_en = 1'b1;
    idle(3);
    key_n[5:4] = 2'b00;
    @(negedge clk);
    chk("R10 irq with filter", {7'd0, irq}, 8'h01);
    chk("R9 filtered read", rd_data, 8'hEF);

    // R1: reset again returns the select to neither group
    rst_n = 1'b0;
    key_n = 8'hFF;
    filter_en = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset after use", rd_data, 8'hFF);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule